// File: doc/BRIEF.md
# Spike-Timing Weight Update Engine

This block applies a simplified spike-timing-dependent plasticity rule to a bank of synaptic weights. It is started for one evaluated time step `t`. It runs only after the neuron core has completed step `t+1`, so that spikes arriving after a post-synaptic firing are already recorded. It first reads the post-synaptic spike word for step `t`. If no post-synaptic neuron fired, it finishes at once. Otherwise it reads a window of pre-synaptic spike words and ORs them into two vectors. The "before" vector covers inputs that fired in the steps leading up to `t`. The "after" vector covers inputs that fired in the steps following `t`.

For every post-synaptic neuron that fired, taken lowest index first, the engine walks the pre-synaptic inputs that are set in exactly one of the two vectors. It walks them lowest index first, using a lowest-set-bit picker. For each one it reads the 8-bit unsigned weight. It increments the weight by one for a "before" input and decrements it by one for an "after" input, saturating at 255 and at 0, and writes the result back. All three memories are external synchronous RAMs with one cycle of read latency.

Top module: `stdp_engine`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and no memory strobe (`post_rd_o`, `pre_rd_o`, `w_rd_o`, `w_we_o`) is asserted.
- R2: A `start_i` pulse while idle causes, in the next cycle, `busy_o` high and a post-spike read with `post_addr_o` equal to the `step_i` value captured with the pulse.
- R3: If the post-spike word read for step `t` is all zero, the engine makes no pre-spike read and no weight access, and raises `done_o`.
- R4: If any post-synaptic neuron fired, exactly WIN_BEFORE+WIN_AFTER pre-spike reads are made, in this order: steps `t-WIN_BEFORE` through `t-1`, then steps `t+1` through `t+WIN_AFTER`. Step addresses wrap modulo 2^STEP_W. The word for step `t` itself is not read.
- R5: For each firing post neuron `j`, each pre input `i` that is set only in the "before" vector has its weight increased by 1, with the result held at 255 if the weight was already 255.
- R6: For each firing post neuron `j`, each pre input `i` that is set only in the "after" vector has its weight decreased by 1, with the result held at 0 if the weight was already 0.
- R7: A pre input set in both vectors causes no weight change and no weight write.
- R8: Weights of non-firing post neurons, and of pre inputs set in neither vector, are left unchanged.
- R9: The weight address is `{post index, pre index}`, with the pre index in the low $clog2(N_PRE) bits. Each update takes 2 cycles: a read, then, in the next cycle, a write to the same address using the read data.
- R10: Weight writes occur in ascending post index order and, within one post neuron, in ascending pre index order.
- R11: `done_o` is a single-cycle pulse with `busy_o` low. A `start_i` arriving while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin evaluation of one time step |
| step_i | input | STEP_W | Time step to evaluate |
| busy_o | output | 1 | Engine is working |
| done_o | output | 1 | One-cycle completion pulse |
| post_rd_o | output | 1 | Post-spike memory read strobe |
| post_addr_o | output | STEP_W | Post-spike memory address (time step) |
| post_data_i | input | N_POST | Post-spike word, valid the cycle after the read |
| pre_rd_o | output | 1 | Pre-spike memory read strobe |
| pre_addr_o | output | STEP_W | Pre-spike memory address (time step) |
| pre_data_i | input | N_PRE | Pre-spike word, valid the cycle after the read |
| w_rd_o | output | 1 | Weight memory read strobe |
| w_we_o | output | 1 | Weight memory write strobe |
| w_addr_o | output | $clog2(N_POST)+$clog2(N_PRE) | Weight address {post, pre} |
| w_wdata_o | output | W_W | Updated weight |
| w_rdata_i | input | W_W | Weight read data, valid the cycle after the read |

## Verification
The bench sweeps every evaluated step of a 16-step memory, including steps 0, 1 and 15, where the window wraps. An engine that did not wrap its step addresses would read the wrong words and update the wrong inputs. It covers all sixteen post-spike patterns, including the all-zero pattern. A design that ignored the skip rule would make pre-spike reads or weight writes where none are allowed. It fills the weights heavily with 0, 1, 254 and 255 and sets pre words to all ones, which makes inputs fall in both windows. Missing saturation would show up as 255 wrapping to 0 or 0 wrapping to 255. Missing cancellation would show up as a stray write or a changed weight. A spurious start in the middle of a run checks that a second request does not restart the sequence or change its results.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POST_RD,
    ST_POST_WAIT,
    ST_PRE_RD,
    ST_PRE_ACC,
    ST_NEXT_POST,
    ST_W_PICK,
    ST_W_UPD,
    ST_FIN
  } stdp_state_e;
endpackage

// File: rtl/stdp_lsb_pick.sv
// Lowest-set-bit picker: index of lowest one, and the vector with it cleared.
module stdp_lsb_pick #(
  parameter int W  = 16,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  rest_o
);
  logic [W-1:0] onehot;

  assign onehot  = vec_i & (~vec_i + W'(1));
  assign rest_o  = vec_i ^ onehot;
  assign valid_o = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/stdp_sat_step.sv
// Unsigned +1 / -1 with saturation at both ends.
module stdp_sat_step #(
  parameter int W_W = 8
) (
  input  logic [W_W-1:0] w_i,
  input  logic           inc_i,
  output logic [W_W-1:0] w_o
);
  localparam logic [W_W-1:0] WMAX = '1;

  always_comb begin
    if (inc_i) w_o = (w_i == WMAX) ? w_i : w_i + W_W'(1);
    else       w_o = (w_i == '0)   ? w_i : w_i - W_W'(1);
  end
endmodule

// File: rtl/stdp_window_acc.sv
// Walks the pre-spike window and ORs words into before/after vectors.
module stdp_window_acc #(
  parameter int N_PRE      = 16,
  parameter int STEP_W     = 8,
  parameter int WIN_BEFORE = 2,
  parameter int WIN_AFTER  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              issue_i,
  input  logic              acc_i,
  input  logic [STEP_W-1:0] base_i,
  input  logic [N_PRE-1:0]  pre_data_i,
  output logic [STEP_W-1:0] addr_o,
  output logic              last_o,
  output logic [N_PRE-1:0]  before_o,
  output logic [N_PRE-1:0]  after_o
);
  localparam int TOTAL = WIN_BEFORE + WIN_AFTER;
  localparam int KW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic [KW-1:0] k_q;
  logic          in_before;

  assign in_before = int'(k_q) < WIN_BEFORE;
  assign last_o    = int'(k_q) == TOTAL - 1;

  always_comb begin
    if (in_before) addr_o = base_i - STEP_W'(WIN_BEFORE) + STEP_W'(k_q);
    else           addr_o = base_i + STEP_W'(1) + STEP_W'(int'(k_q) - WIN_BEFORE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q      <= '0;
      before_o <= '0;
      after_o  <= '0;
    end else if (clear_i) begin
      k_q      <= '0;
      before_o <= '0;
      after_o  <= '0;
    end else if (acc_i) begin
      if (in_before) before_o <= before_o | pre_data_i;
      else           after_o  <= after_o | pre_data_i;
      if (!last_o) k_q <= k_q + KW'(1);
    end
  end

  // R4
  acc_after_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> $past(issue_i));

  // R4
  win_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (int'(k_q) < TOTAL));
endmodule

// File: rtl/stdp_engine.sv
module stdp_engine
  import stdp_pkg::*;
#(
  parameter int N_PRE      = 16,
  parameter int N_POST     = 8,
  parameter int W_W        = 8,
  parameter int STEP_W     = 8,
  parameter int WIN_BEFORE = 2,
  parameter int WIN_AFTER  = 1,
  parameter int PRE_IW     = (N_PRE > 1) ? $clog2(N_PRE) : 1,
  parameter int POST_IW    = (N_POST > 1) ? $clog2(N_POST) : 1,
  parameter int WAW        = PRE_IW + POST_IW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              post_rd_o,
  output logic [STEP_W-1:0] post_addr_o,
  input  logic [N_POST-1:0] post_data_i,
  output logic              pre_rd_o,
  output logic [STEP_W-1:0] pre_addr_o,
  input  logic [N_PRE-1:0]  pre_data_i,
  output logic              w_rd_o,
  output logic              w_we_o,
  output logic [WAW-1:0]    w_addr_o,
  output logic [W_W-1:0]    w_wdata_o,
  input  logic [W_W-1:0]    w_rdata_i
);
  localparam logic [W_W-1:0] WMAX = '1;

  stdp_state_e state_q, state_d;

  logic [STEP_W-1:0]  step_q;
  logic [N_POST-1:0]  post_vec_q;
  logic [POST_IW-1:0] post_idx_q;
  logic [N_PRE-1:0]   work_q;
  logic               dir_q;
  logic [WAW-1:0]     waddr_q;

  logic               post_valid;
  logic [POST_IW-1:0] post_pick;
  logic [N_POST-1:0]  post_rest;
  logic               pre_valid;
  logic [PRE_IW-1:0]  pre_pick;
  logic [N_PRE-1:0]   pre_rest;

  logic               win_last;
  logic [N_PRE-1:0]   before_v, after_v;
  logic [STEP_W-1:0]  win_addr;
  logic [WAW-1:0]     pick_addr;

  stdp_lsb_pick #(.W(N_POST), .IW(POST_IW)) u_post_pick (
    .vec_i(post_vec_q), .valid_o(post_valid), .idx_o(post_pick), .rest_o(post_rest)
  );

  stdp_lsb_pick #(.W(N_PRE), .IW(PRE_IW)) u_pre_pick (
    .vec_i(work_q), .valid_o(pre_valid), .idx_o(pre_pick), .rest_o(pre_rest)
  );

  stdp_window_acc #(
    .N_PRE(N_PRE), .STEP_W(STEP_W), .WIN_BEFORE(WIN_BEFORE), .WIN_AFTER(WIN_AFTER)
  ) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (state_q == ST_POST_WAIT),
    .issue_i    (state_q == ST_PRE_RD),
    .acc_i      (state_q == ST_PRE_ACC),
    .base_i     (step_q),
    .pre_data_i (pre_data_i),
    .addr_o     (win_addr),
    .last_o     (win_last),
    .before_o   (before_v),
    .after_o    (after_v)
  );

  stdp_sat_step #(.W_W(W_W)) u_sat (
    .w_i(w_rdata_i), .inc_i(dir_q), .w_o(w_wdata_o)
  );

  assign pick_addr   = {post_idx_q, pre_pick};
  assign post_rd_o   = state_q == ST_POST_RD;
  assign post_addr_o = step_q;
  assign pre_rd_o    = state_q == ST_PRE_RD;
  assign pre_addr_o  = win_addr;
  assign w_rd_o      = (state_q == ST_W_PICK) && pre_valid;
  assign w_we_o      = state_q == ST_W_UPD;
  assign w_addr_o    = (state_q == ST_W_UPD) ? waddr_q : pick_addr;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign done_o      = state_q == ST_FIN;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_POST_RD;
      ST_POST_RD:   state_d = ST_POST_WAIT;
      ST_POST_WAIT: state_d = (|post_data_i) ? ST_PRE_RD : ST_FIN;
      ST_PRE_RD:    state_d = ST_PRE_ACC;
      ST_PRE_ACC:   state_d = win_last ? ST_NEXT_POST : ST_PRE_RD;
      ST_NEXT_POST: state_d = post_valid ? ST_W_PICK : ST_FIN;
      ST_W_PICK:    state_d = pre_valid ? ST_W_UPD : ST_NEXT_POST;
      ST_W_UPD:     state_d = ST_W_PICK;
      ST_FIN:       state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      post_vec_q <= '0;
      post_idx_q <= '0;
      work_q     <= '0;
      dir_q      <= 1'b0;
      waddr_q    <= '0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_IDLE:      if (start_i) step_q <= step_i;
        ST_POST_WAIT: post_vec_q <= post_data_i;
        ST_NEXT_POST: if (post_valid) begin
          post_idx_q <= post_pick;
          post_vec_q <= post_rest;
          work_q     <= before_v ^ after_v; // inputs in both windows cancel
        end
        ST_W_PICK: if (pre_valid) begin
          dir_q   <= before_v[pre_pick];
          waddr_q <= pick_addr;
          work_q  <= pre_rest;
        end
        default: ;
      endcase
    end
  end

  // R9
  rmw_same_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_we_o |-> ($past(w_rd_o) && (w_addr_o == $past(w_addr_o))));

  // R5 R6
  step_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_we_o |-> ((w_wdata_o == w_rdata_i + W_W'(1)) || (w_wdata_o == w_rdata_i - W_W'(1)) ||
                ((w_wdata_o == w_rdata_i) && ((w_rdata_i == '0) || (w_rdata_i == WMAX)))));

  // R2
  post_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (post_rd_o && (post_addr_o == $past(step_i))));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R1
  one_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({post_rd_o, pre_rd_o, w_rd_o, w_we_o}));

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(pre_rd_o || w_rd_o || w_we_o || post_rd_o));
endmodule

// File: tb/stdp_engine_tb_top.sv
`timescale 1ns/1ps
module stdp_engine_tb_top;
  localparam int NPRE = 8;
  localparam int NPOST = 4;
  localparam int SW = 4;
  localparam int NSTEP = 16;
  localparam int WB = 2;
  localparam int WA = 1;
  localparam int AW = 5;
  localparam int NW = NPRE * NPOST;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SW-1:0] step = '0;
  logic busy, done, post_rd, pre_rd, w_rd, w_we;
  logic [SW-1:0] post_addr, pre_addr;
  logic [NPOST-1:0] post_data = '0;
  logic [NPRE-1:0] pre_data = '0;
  logic [AW-1:0] w_addr;
  logic [7:0] w_wdata;
  logic [7:0] w_rdata = '0;

  always #5 clk = ~clk;

  stdp_engine #(
    .N_PRE(NPRE), .N_POST(NPOST), .W_W(8), .STEP_W(SW), .WIN_BEFORE(WB), .WIN_AFTER(WA)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step),
    .busy_o(busy), .done_o(done),
    .post_rd_o(post_rd), .post_addr_o(post_addr), .post_data_i(post_data),
    .pre_rd_o(pre_rd), .pre_addr_o(pre_addr), .pre_data_i(pre_data),
    .w_rd_o(w_rd), .w_we_o(w_we), .w_addr_o(w_addr), .w_wdata_o(w_wdata), .w_rdata_i(w_rdata)
  );

  logic [NPOST-1:0] post_mem [NSTEP];
  logic [NPRE-1:0]  pre_mem  [NSTEP];
  logic [7:0]       w_mem    [NW];
  logic [7:0]       exp_w    [NW];
  string            exp_tag  [NW];

  always @(posedge clk) begin
    if (post_rd) post_data <= post_mem[post_addr];
    if (pre_rd)  pre_data  <= pre_mem[pre_addr];
    if (w_rd)    w_rdata   <= w_mem[w_addr];
    if (w_we)    w_mem[w_addr] <= w_wdata;
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int wr_log [256];
  int wr_n;
  int pre_log [16];
  int pre_n;
  int done_n;
  logic prev_rd;
  logic [AW-1:0] prev_addr;

  // monitor: R9 read-then-write on same address
  always @(negedge clk) begin
    if (w_we) begin
      checks++;
      if (!(prev_rd && prev_addr == w_addr)) begin
        errors++;
        $display("FAIL R9: write addr %0d prev_rd %0b prev_addr %0d, expected read of same addr one cycle earlier",
                 w_addr, prev_rd, prev_addr);
      end
      if (wr_n < 256) wr_log[wr_n] = int'(w_addr);
      wr_n++;
    end
    if (pre_rd) begin
      if (pre_n < 16) pre_log[pre_n] = int'(pre_addr);
      pre_n++;
    end
    if (done) done_n++;
    prev_rd   = w_rd;
    prev_addr = w_addr;
  end

  int unsigned seed = 32'h1234_5678;
  function automatic int unsigned nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run_trial(input int t, input bit spurious);
    int exp_addr [256];
    int exp_n = 0;
    int exp_pre [16];
    int exp_pre_n = 0;
    logic [NPRE-1:0] bv, av;
    int cyc;
    bv = '0;
    av = '0;
    for (int k = 1; k <= WB; k++) bv |= pre_mem[(t - k + NSTEP) % NSTEP];
    for (int k = 1; k <= WA; k++) av |= pre_mem[(t + k) % NSTEP];
    if (post_mem[t] != '0) begin
      for (int k = 0; k < WB; k++) exp_pre[exp_pre_n++] = (t - WB + k + NSTEP) % NSTEP;
      for (int k = 1; k <= WA; k++) exp_pre[exp_pre_n++] = (t + k) % NSTEP;
    end
    for (int j = 0; j < NPOST; j++) begin
      for (int i = 0; i < NPRE; i++) begin
        int a = j * NPRE + i;
        exp_w[a] = w_mem[a];
        exp_tag[a] = "R8";
        if (post_mem[t][j]) begin
          if (bv[i] && av[i]) exp_tag[a] = "R7";
          else if (bv[i]) begin
            exp_tag[a] = "R5";
            exp_w[a] = (w_mem[a] == 8'hFF) ? 8'hFF : w_mem[a] + 8'd1;
            exp_addr[exp_n++] = a;
          end else if (av[i]) begin
            exp_tag[a] = "R6";
            exp_w[a] = (w_mem[a] == 8'h00) ? 8'h00 : w_mem[a] - 8'd1;
            exp_addr[exp_n++] = a;
          end
        end
      end
    end
    wr_n = 0; pre_n = 0; done_n = 0;
    @(negedge clk);
    start = 1'b1;
    step = SW'(t);
    @(negedge clk);
    start = 1'b0;
    step = SW'((t + 7) % NSTEP);
    // R2
    chk(busy && post_rd && int'(post_addr) == t, "R2", int'(post_addr), t);
    if (spurious) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    // R11
    chk(done && !busy, "R11", int'({done, busy}), 2);
    @(negedge clk);
    chk(!done && !busy, "R11", int'({done, busy}), 0);
    repeat (3) @(negedge clk);
    chk(done_n == 1 && !busy, "R11", done_n, 1);
    // R3 R4
    chk(pre_n == exp_pre_n, (exp_pre_n == 0) ? "R3" : "R4", pre_n, exp_pre_n);
    for (int k = 0; k < exp_pre_n && k < pre_n; k++)
      chk(pre_log[k] == exp_pre[k], "R4", pre_log[k], exp_pre[k]);
    // R10 R7
    chk(wr_n == exp_n, "R7", wr_n, exp_n);
    for (int k = 0; k < exp_n && k < wr_n; k++)
      chk(wr_log[k] == exp_addr[k], "R10", wr_log[k], exp_addr[k]);
    for (int a = 0; a < NW; a++)
      chk(w_mem[a] == exp_w[a], exp_tag[a], int'(w_mem[a]), int'(exp_w[a]));
  endtask

  task automatic fill(input int tr);
    for (int s = 0; s < NSTEP; s++) begin
      post_mem[s] = NPOST'(nxt());
      pre_mem[s]  = NPRE'(nxt() & nxt());
      if (tr % 8 == 3) pre_mem[s] = '1;
    end
    for (int a = 0; a < NW; a++) begin
      int unsigned r = nxt() % 6;
      case (r)
        0: w_mem[a] = 8'h00;
        1: w_mem[a] = 8'hFF;
        2: w_mem[a] = 8'h01;
        3: w_mem[a] = 8'hFE;
        default: w_mem[a] = 8'(nxt());
      endcase
    end
  endtask

  initial begin
    for (int s = 0; s < NSTEP; s++) begin post_mem[s] = '0; pre_mem[s] = '0; end
    for (int a = 0; a < NW; a++) w_mem[a] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !post_rd && !pre_rd && !w_rd && !w_we, "R1",
        int'({busy, done, post_rd, pre_rd, w_rd, w_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !post_rd && !pre_rd && !w_rd && !w_we, "R1",
        int'({busy, done, post_rd, pre_rd, w_rd, w_we}), 0);
    for (int tr = 0; tr < 64; tr++) begin
      int t = tr % NSTEP;
      fill(tr);
      if (tr < 16) post_mem[t] = NPOST'(tr);   // all post patterns, incl. zero (R3)
      if (tr == 5) post_mem[t] = 4'b0101;
      run_trial(t, tr == 5);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule